// File: doc/BRIEF.md
# Single-Precision Float to Signed Integer Converter

This block turns a 32-bit binary floating-point word into a two's complement 32-bit integer. The word carries a sign in its top bit, an 8-bit exponent biased by 127 in bits 30 down to 23, and a 23-bit fraction in the low bits. The caller selects one of four rounding directions for each input. Inputs that have no integer value, or whose value will not fit, produce a saturated result and raise an invalid flag. An inexact flag reports that the conversion lost nonzero fraction bits.

The datapath is purely combinational. It classifies the input, restores the hidden leading one, and shifts the significand so that the binary point sits at a fixed place. It keeps a guard bit and a sticky bit from the bits it discards and uses them to round. A single output register gives a latency of one cycle, and the block accepts a new word on every cycle.

Top module: `f2i_conv`

## Requirements
- R1: For a normal input with biased exponent E and fraction f, the magnitude is (1.f) x 2^(E-127). An input whose value is an integer that fits converts exactly, with the sign applied, and both flags stay low.
- R2: Mode 2'b00 rounds to the nearest integer. An exact half goes to the even neighbour, so 2.5 gives 2, 3.5 gives 4, 0.5 gives 0 and -2.5 gives -2.
- R3: Mode 2'b01 rounds toward zero by dropping the fraction bits, so 1.9 gives 1 and -1.9 gives -1.
- R4: Mode 2'b10 rounds toward plus infinity, so 2.1 gives 3, -2.1 gives -2 and 2.5 gives 3.
- R5: Mode 2'b11 rounds toward minus infinity, so 1.9 gives 1, -1.9 gives -2 and -2.5 gives -3.
- R6: An exponent field of 0 (signed zero or subnormal) has a magnitude below 1. Zero gives 0 and is exact. A subnormal gives 0, except that mode 2'b10 on a positive subnormal gives 1 and mode 2'b11 on a negative subnormal gives -1.
- R7: An exponent field of 255 with a nonzero fraction (NaN) gives 0x7FFFFFFF with invalid set, for either sign.
- R8: Infinity, and any rounded value outside [-2^31, 2^31-1], gives 0x7FFFFFFF when positive and 0x80000000 when negative, with invalid set. Exactly -2^31 converts normally with invalid clear.
- R9: Inexact is set exactly when nonzero fraction bits are discarded on a conversion that is not invalid. It is clear whenever invalid is set.
- R10: The result and flags for a word taken with valid_i high appear with valid_o high on the next cycle, for back-to-back words. In a cycle after valid_i was low, valid_o is low and the result and flags hold their values. Reset clears all outputs.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| valid_i | input | 1 | Input word is valid this cycle |
| flt_i | input | 32 | Floating-point operand |
| mode_i | input | 2 | Rounding direction: 00 nearest-even, 01 toward zero, 10 toward +inf, 11 toward -inf |
| valid_o | output | 1 | Result registers were loaded in the previous cycle |
| int_o | output | 32 | Signed integer result |
| invalid_o | output | 1 | NaN, infinity or out-of-range input |
| inexact_o | output | 1 | Nonzero fraction bits were discarded |

## Verification
The input values are chosen so that each rounding mode produces a different result from the others. They are a value just below an integer, a value just above one, an exact half and a value just past a half, each with both signs. Between them they show whether the guard bit, the sticky bit and the even-LSB rule are used correctly. Exact integers with exponents of 23 and 30 exercise the left-shift path and the widest in-range value. Two values bracket the point of overflow: exactly -2^31, and one step beyond it. Zeros, subnormals, an exponent of -2, infinities and NaNs of both signs test each special class. They also show that a directed mode pushes a tiny value away from zero only on the matching side.

// File: rtl/f2i_pkg.sv
package f2i_pkg;

  typedef enum logic [1:0] {
    RND_NEAR_EVEN = 2'b00,
    RND_ZERO      = 2'b01,
    RND_UP        = 2'b10,
    RND_DOWN      = 2'b11
  } rnd_mode_e;

  typedef enum logic [2:0] {
    CLS_ZERO,
    CLS_SUB,
    CLS_NORM,
    CLS_INF,
    CLS_NAN
  } fcls_e;

endpackage

// File: rtl/f2i_decode.sv
module f2i_decode
  import f2i_pkg::*;
#(
  parameter int EXP_W  = 8,
  parameter int FRAC_W = 23,
  localparam int FLT_W = EXP_W + FRAC_W + 1,
  localparam int UE_W  = EXP_W + 2
) (
  input  logic [FLT_W-1:0]       flt_i,
  output logic                   sign_o,
  output fcls_e                  cls_o,
  output logic [FRAC_W:0]        sig_o,
  output logic signed [UE_W-1:0] uexp_o
);

  localparam int BIAS = (2 ** (EXP_W - 1)) - 1;
  localparam logic signed [UE_W-1:0] BIAS_S = UE_W'(BIAS);
  localparam logic signed [UE_W-1:0] SUB_E  = UE_W'(1 - BIAS);

  logic [EXP_W-1:0]  exp_f;
  logic [FRAC_W-1:0] frac_f;
  logic              exp_zero, exp_ones, frac_zero;

  assign sign_o    = flt_i[FLT_W-1];
  assign exp_f     = flt_i[FLT_W-2:FRAC_W];
  assign frac_f    = flt_i[FRAC_W-1:0];
  assign exp_zero  = (exp_f == '0);
  assign exp_ones  = (exp_f == '1);
  assign frac_zero = (frac_f == '0);

  always_comb begin
    cls_o  = CLS_NORM;
    sig_o  = {1'b1, frac_f};
    uexp_o = $signed({2'b00, exp_f}) - BIAS_S;
    if (exp_zero) begin
      // no hidden one below the normal range
      sig_o  = {1'b0, frac_f};
      uexp_o = SUB_E;
      cls_o  = frac_zero ? CLS_ZERO : CLS_SUB;
    end else if (exp_ones) begin
      cls_o = frac_zero ? CLS_INF : CLS_NAN;
    end
  end

endmodule

// File: rtl/f2i_align.sv
module f2i_align
  import f2i_pkg::*;
#(
  parameter int EXP_W  = 8,
  parameter int FRAC_W = 23,
  parameter int INT_W  = 32,
  localparam int UE_W  = EXP_W + 2
) (
  input  fcls_e                  cls_i,
  input  logic [FRAC_W:0]        sig_i,
  input  logic signed [UE_W-1:0] uexp_i,
  output logic [INT_W:0]         int_o,
  output logic                   grd_o,
  output logic                   stk_o,
  output logic                   big_o
);

  // binary point sits FRAC_W+1 bits above the LSB of the wide vector
  localparam int WIDE = INT_W + FRAC_W + 2;
  localparam int SH_W = $clog2(INT_W + 2);
  localparam logic signed [UE_W-1:0] LIM_HI = UE_W'(INT_W);
  localparam logic signed [UE_W-1:0] LIM_LO = -UE_W'(1);
  localparam logic signed [UE_W-1:0] ONE_S  = UE_W'(1);

  logic signed [UE_W-1:0] ue_p1;
  logic [SH_W-1:0]        shamt;
  logic [WIDE-1:0]        wide;

  assign ue_p1 = uexp_i + ONE_S;
  assign shamt = SH_W'(ue_p1);
  assign wide  = {{(WIDE-FRAC_W-1){1'b0}}, sig_i} << shamt;

  always_comb begin
    int_o = '0;
    grd_o = 1'b0;
    stk_o = 1'b0;
    big_o = 1'b0;
    unique case (cls_i)
      CLS_NORM: begin
        if (uexp_i > LIM_HI) begin
          big_o = 1'b1;
        end else if (uexp_i < LIM_LO) begin
          stk_o = 1'b1;  // below one half, nonzero
        end else begin
          int_o = wide[WIDE-1:FRAC_W+1];
          grd_o = wide[FRAC_W];
          stk_o = |wide[FRAC_W-1:0];
        end
      end
      CLS_SUB: stk_o = 1'b1;
      default: ;
    endcase
  end

endmodule

// File: rtl/f2i_round.sv
module f2i_round
  import f2i_pkg::*;
#(
  parameter int INT_W = 32
) (
  input  logic             sign_i,
  input  fcls_e            cls_i,
  input  logic [INT_W:0]   int_i,
  input  logic             grd_i,
  input  logic             stk_i,
  input  logic             big_i,
  input  rnd_mode_e        mode_i,
  output logic [INT_W-1:0] res_o,
  output logic             inv_o,
  output logic             inx_o
);

  localparam logic [INT_W+1:0] POS_LIM = {3'b000, {(INT_W-1){1'b1}}};
  localparam logic [INT_W+1:0] NEG_LIM = {3'b001, {(INT_W-1){1'b0}}};
  localparam logic [INT_W-1:0] SAT_POS = {1'b0, {(INT_W-1){1'b1}}};
  localparam logic [INT_W-1:0] SAT_NEG = {1'b1, {(INT_W-1){1'b0}}};
  localparam logic [INT_W-1:0] ONE_I   = {{(INT_W-1){1'b0}}, 1'b1};

  logic             lost, inc, ovf;
  logic [INT_W+1:0] mag_r;
  logic [INT_W-1:0] mag_lo;

  assign lost = grd_i | stk_i;

  always_comb begin
    unique case (mode_i)
      RND_NEAR_EVEN: inc = grd_i & (stk_i | int_i[0]);
      RND_ZERO:      inc = 1'b0;
      RND_UP:        inc = lost & ~sign_i;
      RND_DOWN:      inc = lost & sign_i;
      default:       inc = 1'b0;
    endcase
  end

  assign mag_r  = {1'b0, int_i} + {{(INT_W+1){1'b0}}, inc};
  assign mag_lo = mag_r[INT_W-1:0];
  assign ovf    = big_i | (sign_i ? (mag_r > NEG_LIM) : (mag_r > POS_LIM));

  always_comb begin
    res_o = sign_i ? ((~mag_lo) + ONE_I) : mag_lo;
    inv_o = 1'b0;
    inx_o = lost;
    if (cls_i == CLS_NAN) begin
      res_o = SAT_POS;
      inv_o = 1'b1;
      inx_o = 1'b0;
    end else if (cls_i == CLS_INF || ovf) begin
      res_o = sign_i ? SAT_NEG : SAT_POS;
      inv_o = 1'b1;
      inx_o = 1'b0;
    end
  end

endmodule

// File: rtl/f2i_conv.sv
module f2i_conv
  import f2i_pkg::*;
#(
  parameter int EXP_W  = 8,
  parameter int FRAC_W = 23,
  parameter int INT_W  = 32,
  localparam int FLT_W = EXP_W + FRAC_W + 1,
  localparam int UE_W  = EXP_W + 2
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             valid_i,
  input  logic [FLT_W-1:0] flt_i,
  input  logic [1:0]       mode_i,
  output logic             valid_o,
  output logic [INT_W-1:0] int_o,
  output logic             invalid_o,
  output logic             inexact_o
);

  localparam logic [INT_W-1:0] SAT_POS = {1'b0, {(INT_W-1){1'b1}}};
  localparam logic [INT_W-1:0] SAT_NEG = {1'b1, {(INT_W-1){1'b0}}};
  localparam logic [INT_W-1:0] ONE_I   = {{(INT_W-1){1'b0}}, 1'b1};

  logic                   sign;
  fcls_e                  cls;
  logic [FRAC_W:0]        sig;
  logic signed [UE_W-1:0] uexp;
  logic [INT_W:0]         int_mag;
  logic                   grd, stk, big;
  logic [INT_W-1:0]       res_d;
  logic                   inv_d, inx_d;
  rnd_mode_e              mode;

  assign mode = rnd_mode_e'(mode_i);

  f2i_decode #(.EXP_W(EXP_W), .FRAC_W(FRAC_W)) i_decode (
    .flt_i  (flt_i),
    .sign_o (sign),
    .cls_o  (cls),
    .sig_o  (sig),
    .uexp_o (uexp)
  );

  f2i_align #(.EXP_W(EXP_W), .FRAC_W(FRAC_W), .INT_W(INT_W)) i_align (
    .cls_i  (cls),
    .sig_i  (sig),
    .uexp_i (uexp),
    .int_o  (int_mag),
    .grd_o  (grd),
    .stk_o  (stk),
    .big_o  (big)
  );

  f2i_round #(.INT_W(INT_W)) i_round (
    .sign_i (sign),
    .cls_i  (cls),
    .int_i  (int_mag),
    .grd_i  (grd),
    .stk_i  (stk),
    .big_i  (big),
    .mode_i (mode),
    .res_o  (res_d),
    .inv_o  (inv_d),
    .inx_o  (inx_d)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      valid_o   <= 1'b0;
      int_o     <= '0;
      invalid_o <= 1'b0;
      inexact_o <= 1'b0;
    end else begin
      valid_o <= valid_i;
      if (valid_i) begin
        int_o     <= res_d;
        invalid_o <= inv_d;
        inexact_o <= inx_d;
      end
    end
  end

  // R8
  sat_value_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    valid_o && invalid_o |-> (int_o == SAT_POS || int_o == SAT_NEG));

  // R9
  flag_excl_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    valid_o |-> !(invalid_o && inexact_o));

  // R1
  sign_match_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    valid_o && !invalid_o && int_o != '0 |-> int_o[INT_W-1] == $past(flt_i[FLT_W-1]));

  // R6
  tiny_result_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    valid_o && $past(flt_i[FLT_W-2:FRAC_W]) == '0 |->
      (int_o == '0 || int_o == ONE_I || int_o == '1) && !invalid_o);

  // R7
  nan_sat_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    valid_o && $past(flt_i[FLT_W-2:FRAC_W]) == '1 && $past(flt_i[FRAC_W-1:0]) != '0
      |-> int_o == SAT_POS && invalid_o);

  // R10
  idle_hold_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !valid_i |=> !valid_o && $stable(int_o) && $stable(invalid_o) && $stable(inexact_o));

endmodule

// File: tb/test_f2i_conv.sv
module test_f2i_conv;

  logic        clk_i = 1'b0;
  logic        rst_ni = 1'b0;
  logic        valid_i = 1'b0;
  logic [31:0] flt_i = '0;
  logic [1:0]  mode_i = '0;
  logic        valid_o;
  logic [31:0] int_o;
  logic        invalid_o, inexact_o;

  int n_chk = 0;
  int n_fail = 0;
  int cyc = 0;

  always #10 clk_i = ~clk_i;

  f2i_conv i_f2i_conv (
    .clk_i, .rst_ni, .valid_i, .flt_i, .mode_i,
    .valid_o, .int_o, .invalid_o, .inexact_o
  );

  // {req, float, mode, result, invalid, inexact}
  localparam int NV = 40;
  localparam logic [71:0] VEC [NV] = '{
    {4'd1,  32'h3F800000, 2'd0, 32'h00000001, 1'b0, 1'b0},  // R1 1.0
    {4'd1,  32'h42F60000, 2'd1, 32'h0000007B, 1'b0, 1'b0},  // R1 123.0
    {4'd1,  32'h4B000001, 2'd0, 32'h00800001, 1'b0, 1'b0},  // R1 e=23
    {4'd1,  32'h4EFFFFFF, 2'd3, 32'h7FFFFF80, 1'b0, 1'b0},  // R1 widest in range
    {4'd1,  32'hC2F60000, 2'd2, 32'hFFFFFF85, 1'b0, 1'b0},  // R1 -123.0
    {4'd2,  32'h40200000, 2'd0, 32'h00000002, 1'b0, 1'b1},  // R2 2.5
    {4'd2,  32'h40600000, 2'd0, 32'h00000004, 1'b0, 1'b1},  // R2 3.5
    {4'd2,  32'hC0200000, 2'd0, 32'hFFFFFFFE, 1'b0, 1'b1},  // R2 -2.5
    {4'd2,  32'h3F000000, 2'd0, 32'h00000000, 1'b0, 1'b1},  // R2 0.5
    {4'd2,  32'h3FC00000, 2'd0, 32'h00000002, 1'b0, 1'b1},  // R2 1.5
    {4'd2,  32'h3FF33333, 2'd0, 32'h00000002, 1'b0, 1'b1},  // R2 1.9
    {4'd2,  32'h3F000001, 2'd0, 32'h00000001, 1'b0, 1'b1},  // R2 just over half
    {4'd2,  32'h3E800000, 2'd0, 32'h00000000, 1'b0, 1'b1},  // R2 0.25
    {4'd3,  32'h3FF33333, 2'd1, 32'h00000001, 1'b0, 1'b1},  // R3 1.9
    {4'd3,  32'hBFF33333, 2'd1, 32'hFFFFFFFF, 1'b0, 1'b1},  // R3 -1.9
    {4'd3,  32'h3F400000, 2'd1, 32'h00000000, 1'b0, 1'b1},  // R3 0.75
    {4'd4,  32'h40066666, 2'd2, 32'h00000003, 1'b0, 1'b1},  // R4 2.1
    {4'd4,  32'hC0066666, 2'd2, 32'hFFFFFFFE, 1'b0, 1'b1},  // R4 -2.1
    {4'd4,  32'h40200000, 2'd2, 32'h00000003, 1'b0, 1'b1},  // R4 2.5
    {4'd4,  32'hC0200000, 2'd2, 32'hFFFFFFFE, 1'b0, 1'b1},  // R4 -2.5
    {4'd5,  32'h3FF33333, 2'd3, 32'h00000001, 1'b0, 1'b1},  // R5 1.9
    {4'd5,  32'hBFF33333, 2'd3, 32'hFFFFFFFE, 1'b0, 1'b1},  // R5 -1.9
    {4'd5,  32'hC0200000, 2'd3, 32'hFFFFFFFD, 1'b0, 1'b1},  // R5 -2.5
    {4'd5,  32'h3F400000, 2'd3, 32'h00000000, 1'b0, 1'b1},  // R5 0.75
    {4'd6,  32'h00000000, 2'd0, 32'h00000000, 1'b0, 1'b0},  // R6 +0
    {4'd6,  32'h80000000, 2'd3, 32'h00000000, 1'b0, 1'b0},  // R6 -0
    {4'd6,  32'h00000001, 2'd2, 32'h00000001, 1'b0, 1'b1},  // R6 denorm up
    {4'd6,  32'h80000001, 2'd3, 32'hFFFFFFFF, 1'b0, 1'b1},  // R6 denorm down
    {4'd6,  32'h80400000, 2'd2, 32'h00000000, 1'b0, 1'b1},  // R6 neg denorm up
    {4'd6,  32'h00400000, 2'd0, 32'h00000000, 1'b0, 1'b1},  // R6 denorm nearest
    {4'd7,  32'h7FC00000, 2'd0, 32'h7FFFFFFF, 1'b1, 1'b0},  // R7 NaN
    {4'd7,  32'hFFC00001, 2'd3, 32'h7FFFFFFF, 1'b1, 1'b0},  // R7 negative NaN
    {4'd8,  32'h7F800000, 2'd0, 32'h7FFFFFFF, 1'b1, 1'b0},  // R8 +inf
    {4'd8,  32'hFF800000, 2'd1, 32'h80000000, 1'b1, 1'b0},  // R8 -inf
    {4'd8,  32'h4F000000, 2'd0, 32'h7FFFFFFF, 1'b1, 1'b0},  // R8 2^31
    {4'd8,  32'hCF000000, 2'd0, 32'h80000000, 1'b0, 1'b0},  // R8 -2^31 fits
    {4'd8,  32'hCF000001, 2'd2, 32'h80000000, 1'b1, 1'b0},  // R8 below -2^31
    {4'd8,  32'h5F000000, 2'd0, 32'h7FFFFFFF, 1'b1, 1'b0},  // R8 far out
    {4'd9,  32'h3F800001, 2'd1, 32'h00000001, 1'b0, 1'b1},  // R9 lowest bit lost
    {4'd9,  32'h4B7FFFFF, 2'd2, 32'h00FFFFFF, 1'b0, 1'b0}   // R9 no bits lost
  };

  task automatic check(input string req, input logic [31:0] act_r, input logic act_v,
                       input logic act_i, input logic act_x, input logic [31:0] exp_r,
                       input logic exp_v, input logic exp_i, input logic exp_x);
    n_chk++;
    if (act_r !== exp_r || act_v !== exp_v || act_i !== exp_i || act_x !== exp_x) begin
      n_fail++;
      $display("FAIL %s: got res=%h v=%b inv=%b inx=%b, expected res=%h v=%b inv=%b inx=%b",
               req, act_r, act_v, act_i, act_x, exp_r, exp_v, exp_i, exp_x);
    end
  endtask

  task automatic finish_run();
    $display("  End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  endtask

  always @(posedge clk_i) begin
    cyc++;
    if (cyc > 100000) begin
      n_chk++;
      n_fail++;
      $display("FAIL watchdog: got timeout, expected completion");
      finish_run();
    end
  end

  initial begin
    // R10 reset state
    repeat (3) @(negedge clk_i);
    check("R10 reset", int_o, valid_o, invalid_o, inexact_o, 32'h0, 1'b0, 1'b0, 1'b0);
    rst_ni = 1'b1;

    // back-to-back walk of the vector table
    for (int i = 0; i <= NV; i++) begin
      @(negedge clk_i);
      if (i > 0) begin
        check($sformatf("R%0d vec%0d", VEC[i-1][71:68], i-1), int_o, valid_o, invalid_o,
              inexact_o, VEC[i-1][33:2], 1'b1, VEC[i-1][1], VEC[i-1][0]);
      end
      if (i < NV) begin
        valid_i = 1'b1;
        flt_i   = VEC[i][67:36];
        mode_i  = VEC[i][35:34];
      end else begin
        valid_i = 1'b0;
        flt_i   = 32'h7F800000;
        mode_i  = 2'd0;
      end
    end

    // R10 idle cycle: outputs hold the last result, valid low
    @(negedge clk_i);
    check("R10 idle hold", int_o, valid_o, invalid_o, inexact_o, 32'h00FFFFFF, 1'b0, 1'b0, 1'b0);

    // R10 single word after a gap, then gap again
    valid_i = 1'b1; flt_i = 32'hC0600000; mode_i = 2'd1;  // -3.5 toward zero
    @(negedge clk_i);
    valid_i = 1'b0; flt_i = 32'h7FC00000;
    check("R3 gap word", int_o, valid_o, invalid_o, inexact_o, 32'hFFFFFFFD, 1'b1, 1'b0, 1'b1);
    @(negedge clk_i);
    check("R10 gap hold", int_o, valid_o, invalid_o, inexact_o, 32'hFFFFFFFD, 1'b0, 1'b0, 1'b1);

    // R9 inexact clears on an exact word following an inexact one
    valid_i = 1'b1; flt_i = 32'h41200000; mode_i = 2'd2;  // 10.0
    @(negedge clk_i);
    valid_i = 1'b0;
    check("R9 exact after inexact", int_o, valid_o, invalid_o, inexact_o, 32'h0000000A, 1'b1, 1'b0, 1'b0);

    // R10 reset in the middle of operation
    valid_i = 1'b1; flt_i = 32'h7F800000; mode_i = 2'd0;
    @(negedge clk_i);
    valid_i = 1'b0;
    rst_ni = 1'b0;
    #1;
    check("R10 async reset", int_o, valid_o, invalid_o, inexact_o, 32'h0, 1'b0, 1'b0, 1'b0);
    @(negedge clk_i);
    rst_ni = 1'b1;
    @(negedge clk_i);
    check("R10 after reset", int_o, valid_o, invalid_o, inexact_o, 32'h0, 1'b0, 1'b0, 1'b0);

    finish_run();
  end

endmodule